// File: doc/BRIEF.md
# Supervisor Trap Sequencer

This block keeps the supervisor-level trap state for one hart and runs the two control transfers that state exists for: entering a trap and returning from one. A pipeline reports each instruction boundary's events to it: a synchronous exception with its code, an environment call, and two level-sensitive device interrupt lines. It also pulses a strobe when it retires a return-from-trap instruction. The block picks at most one event per cycle and updates its registers. One cycle later it issues a redirect: the target pc, a one-cycle valid strobe and the new privilege level.

Software reaches the vector base, saved pc, cause, scratch and status registers through a simple read/write port addressed by the usual 12-bit CSR numbers. Only the interrupt-enable, previous-enable and previous-privilege status bits exist. The privilege level is held inside the block, and supervisor is the level out of reset. Only the pc is saved on entry. Saving general registers and switching stacks or page tables are left to the handler software.

Top module: `trap_seq`

## Requirements
- R1: After reset the privilege output is supervisor (1), the redirect strobe is low, and a legal read of any of the five registers returns zero.
- R2: A device interrupt is taken only while the interrupt-enable bit (sstatus bit 1) is set. A line held high while the bit is clear is taken in the cycle after software sets it. Exceptions and environment calls are taken whatever the bit's value.
- R3: On a trap the saved pc (0x141) takes cur_pc_i. One cycle after the event, redirect_valid_o pulses for one cycle with redirect_pc_o equal to the vector base that held before the event, and the privilege becomes supervisor.
- R4: On a trap the previous-enable bit (bit 5) takes the old enable, the enable clears, and the previous-privilege bit (bit 8) takes the old privilege (1 = supervisor).
- R5: The cause register (0x142) is loaded as follows. A synchronous exception gives its 4-bit code with bit 31 clear. An environment call gives 8 from user and 9 from supervisor. The external interrupt gives 0x80000009 and the timer gives 0x80000005, and external wins when both are pending.
- R6: Only one event is acted on per cycle, in the order exception, then environment call, then interrupt, then return. The lower-ranked events of that cycle have no effect.
- R7: For an environment call the saved pc equals the pc of the call instruction itself.
- R8: A return redirects to the saved pc and takes the privilege from the previous-privilege bit. It also sets the enable from previous-enable, sets previous-enable to 1 and clears previous-privilege to user.
- R9: In user mode any read or write asserts csr_illegal_o in the same cycle. The read data is then zero and the write changes no register.
- R10: An access in supervisor mode to an address other than 0x100, 0x105, 0x140, 0x141 and 0x142 asserts csr_illegal_o and returns zero.
- R11: The vector base (0x105) reads with its two low bits zero. In sstatus (0x100) only bits 1, 5 and 8 store a value, and all other bits read zero.
- R12: A register write in the same cycle as a trap or a return is dropped.
- R13: The scratch register (0x140) holds any written 32-bit value and is not changed by traps or returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cur_pc_i | input | XLEN | pc of the instruction at the current boundary |
| exc_req_i | input | 1 | Synchronous exception at this boundary |
| exc_code_i | input | 4 | Exception code |
| ecall_req_i | input | 1 | Environment call at this boundary |
| irq_ext_i | input | 1 | External interrupt line (level) |
| irq_tmr_i | input | 1 | Timer interrupt line (level) |
| sret_i | input | 1 | Return-from-trap strobe |
| csr_re_i | input | 1 | Register read enable |
| csr_we_i | input | 1 | Register write enable |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data, combinational |
| csr_illegal_o | output | 1 | Access refused, combinational |
| redirect_valid_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 1 | Current privilege, 1 = supervisor |

## Verification
The read data and the illegal flag follow the current inputs combinationally, so the bench samples them shortly after it drives the inputs and before the next rising edge. Register writes, trap entry and return all take effect at the next rising edge. The redirect strobe, target and privilege therefore appear one cycle after the event, and the bench samples them at the following falling edge. A behavioural model advances at each rising edge from the same inputs and is compared at both sampling points in every cycle. Directed sequences cover masked interrupts, simultaneous events, user-mode accesses and writes that collide with a trap.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int ADDR_W = 12;
    localparam int CODE_W = 4;

    localparam logic [ADDR_W-1:0] A_STATUS  = 12'h100;
    localparam logic [ADDR_W-1:0] A_TVEC    = 12'h105;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 12'h140;
    localparam logic [ADDR_W-1:0] A_EPC     = 12'h141;
    localparam logic [ADDR_W-1:0] A_CAUSE   = 12'h142;

    localparam int B_IE   = 1;
    localparam int B_PIE  = 5;
    localparam int B_PP   = 8;

    localparam logic PRIV_U = 1'b0;
    localparam logic PRIV_S = 1'b1;

    localparam logic [CODE_W-1:0] C_ECALL_U = 4'd8;
    localparam logic [CODE_W-1:0] C_ECALL_S = 4'd9;
    localparam logic [CODE_W-1:0] C_TIMER   = 4'd5;
    localparam logic [CODE_W-1:0] C_EXT     = 4'd9;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_STATUS, SEL_TVEC, SEL_SCRATCH, SEL_EPC, SEL_CAUSE
    } csr_sel_e;
endpackage

// File: rtl/trap_pick.sv
module trap_pick
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 exc_req,
    input  logic [CODE_W-1:0]    exc_code,
    input  logic                 ecall_req,
    input  logic                 priv,
    input  logic                 sie,
    input  logic                 irq_ext,
    input  logic                 irq_tmr,
    output logic                 take,
    output logic [XLEN-1:0]      cause
);
    logic irq_ok;

    always_comb begin
        irq_ok = sie && (irq_ext || irq_tmr);
        take   = exc_req || ecall_req || irq_ok;
        cause  = '0;
        if (exc_req) begin
            cause[CODE_W-1:0] = exc_code;
        end else if (ecall_req) begin
            cause[CODE_W-1:0] = (priv == PRIV_S) ? C_ECALL_S : C_ECALL_U;
        end else if (irq_ok) begin
            cause[XLEN-1]     = 1'b1;
            cause[CODE_W-1:0] = irq_ext ? C_EXT : C_TIMER;
        end
    end
endmodule

// File: rtl/trap_csr_port.sv
module trap_csr_port
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              re,
    input  logic              we,
    input  logic              priv,
    input  logic              sie,
    input  logic              spie,
    input  logic              spp,
    input  logic [XLEN-1:0]   stvec,
    input  logic [XLEN-1:0]   sepc,
    input  logic [XLEN-1:0]   scause,
    input  logic [XLEN-1:0]   sscratch,
    output csr_sel_e          sel,
    output logic              illegal,
    output logic [XLEN-1:0]   rdata
);
    logic [XLEN-1:0] status_v;
    logic [XLEN-1:0] val;

    always_comb begin
        status_v        = '0;
        status_v[B_IE]  = sie;
        status_v[B_PIE] = spie;
        status_v[B_PP]  = spp;
        unique case (addr)
            A_STATUS:  begin sel = SEL_STATUS;  val = status_v; end
            A_TVEC:    begin sel = SEL_TVEC;    val = stvec;    end
            A_SCRATCH: begin sel = SEL_SCRATCH; val = sscratch; end
            A_EPC:     begin sel = SEL_EPC;     val = sepc;     end
            A_CAUSE:   begin sel = SEL_CAUSE;   val = scause;   end
            default:   begin sel = SEL_NONE;    val = '0;       end
        endcase
        illegal = (re || we) && ((priv == PRIV_U) || (sel == SEL_NONE));
        rdata   = (re && !illegal) ? val : '0;
    end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [XLEN-1:0]   cur_pc_i,
    input  logic              exc_req_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              ecall_req_i,
    input  logic              irq_ext_i,
    input  logic              irq_tmr_i,
    input  logic              sret_i,
    input  logic              csr_re_i,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              csr_illegal_o,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic              priv_o
);
    localparam int TVEC_LSB = 2;

    typedef struct packed {
        logic            priv;
        logic            sie;
        logic            spie;
        logic            spp;
        logic [XLEN-1:0] stvec;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] sscratch;
        logic            rv;
        logic [XLEN-1:0] rpc;
    } st_t;

    st_t st_q, st_d;

    logic            trap_take;
    logic [XLEN-1:0] trap_cause;
    csr_sel_e        sel;
    logic            sie_w, spie_w, spp_w, priv_w;
    logic [XLEN-1:0] stvec_w, sepc_w;

    assign sie_w   = st_q.sie;
    assign spie_w  = st_q.spie;
    assign spp_w   = st_q.spp;
    assign priv_w  = st_q.priv;
    assign stvec_w = st_q.stvec;
    assign sepc_w  = st_q.sepc;

    trap_pick #(.XLEN(XLEN)) u_pick (
        .exc_req   (exc_req_i),
        .exc_code  (exc_code_i),
        .ecall_req (ecall_req_i),
        .priv      (priv_w),
        .sie       (sie_w),
        .irq_ext   (irq_ext_i),
        .irq_tmr   (irq_tmr_i),
        .take      (trap_take),
        .cause     (trap_cause)
    );

    trap_csr_port #(.XLEN(XLEN)) u_port (
        .addr     (csr_addr_i),
        .re       (csr_re_i),
        .we       (csr_we_i),
        .priv     (priv_w),
        .sie      (sie_w),
        .spie     (spie_w),
        .spp      (spp_w),
        .stvec    (stvec_w),
        .sepc     (sepc_w),
        .scause   (st_q.scause),
        .sscratch (st_q.sscratch),
        .sel      (sel),
        .illegal  (csr_illegal_o),
        .rdata    (csr_rdata_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        if (trap_take) begin
            st_d.sepc   = cur_pc_i;
            st_d.scause = trap_cause;
            st_d.spie   = st_q.sie;
            st_d.sie    = 1'b0;
            st_d.spp    = st_q.priv;
            st_d.priv   = PRIV_S;
            st_d.rv     = 1'b1;
            st_d.rpc    = st_q.stvec;
        end else if (sret_i) begin
            st_d.priv   = st_q.spp;
            st_d.sie    = st_q.spie;
            st_d.spie   = 1'b1;
            st_d.spp    = PRIV_U;
            st_d.rv     = 1'b1;
            st_d.rpc    = st_q.sepc;
        end else if (csr_we_i && !csr_illegal_o) begin
            unique case (sel)
                SEL_STATUS: begin
                    st_d.sie  = csr_wdata_i[B_IE];
                    st_d.spie = csr_wdata_i[B_PIE];
                    st_d.spp  = csr_wdata_i[B_PP];
                end
                SEL_TVEC:    st_d.stvec    = {csr_wdata_i[XLEN-1:TVEC_LSB], {TVEC_LSB{1'b0}}};
                SEL_SCRATCH: st_d.sscratch = csr_wdata_i;
                SEL_EPC:     st_d.sepc     = csr_wdata_i;
                SEL_CAUSE:   st_d.scause   = csr_wdata_i;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.priv <= PRIV_S;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid_o = st_q.rv;
    assign redirect_pc_o    = st_q.rpc;
    assign priv_o           = st_q.priv;
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            take,
    input logic            sret_i,
    input logic            exc_req_i,
    input logic            ecall_req_i,
    input logic            irq_ext_i,
    input logic            irq_tmr_i,
    input logic            csr_re_i,
    input logic            csr_we_i,
    input logic            csr_illegal_o,
    input logic [XLEN-1:0] csr_rdata_o,
    input logic            sie,
    input logic            spp,
    input logic            priv,
    input logic [XLEN-1:0] stvec,
    input logic [XLEN-1:0] sepc,
    input logic [XLEN-1:0] cur_pc_i,
    input logic            redirect_valid_o,
    input logic [XLEN-1:0] redirect_pc_o
);
    // R2: masked interrupt alone causes no redirect
    a_r2_masked_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_ext_i || irq_tmr_i) && !sie && !exc_req_i && !ecall_req_i && !sret_i)
        |=> !redirect_valid_o);

    // R3: entry redirects to the prior vector base in supervisor mode
    a_r3_entry_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |=> (redirect_valid_o && redirect_pc_o == $past(stvec) && priv));

    // R4: enable bit cleared inside the handler
    a_r4_sie_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |=> !sie);

    // R7: saved pc is the pc at the trapping boundary
    a_r7_sepc_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |=> sepc == $past(cur_pc_i));

    // R8: return goes to saved pc and saved privilege
    a_r8_sret_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sret_i && !take) |=> (redirect_valid_o && redirect_pc_o == $past(sepc)
                               && priv == $past(spp)));

    // R9: user-mode access refused and reads zero
    a_r9_user_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!priv && (csr_re_i || csr_we_i)) |-> (csr_illegal_o && csr_rdata_o == '0));

    // R9: user-mode write leaves the vector base and saved pc alone
    a_r9_user_nowrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!priv && csr_we_i && !take && !sret_i) |=> ($stable(stvec) && $stable(sepc)));

    // R11: redirect on entry is word aligned to four bytes
    a_r11_vec_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |=> redirect_pc_o[1:0] == 2'b00);
endmodule

bind trap_seq trap_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .take             (trap_take),
    .sret_i           (sret_i),
    .exc_req_i        (exc_req_i),
    .ecall_req_i      (ecall_req_i),
    .irq_ext_i        (irq_ext_i),
    .irq_tmr_i        (irq_tmr_i),
    .csr_re_i         (csr_re_i),
    .csr_we_i         (csr_we_i),
    .csr_illegal_o    (csr_illegal_o),
    .csr_rdata_o      (csr_rdata_o),
    .sie              (sie_w),
    .spp              (spp_w),
    .priv             (priv_w),
    .stvec            (stvec_w),
    .sepc             (sepc_w),
    .cur_pc_i         (cur_pc_i),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o)
);

// File: tb/test_trap_seq.sv
`timescale 1ns/1ps
module test_trap_seq;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] cur_pc = '0;
    logic            exc_req = 1'b0;
    logic [3:0]      exc_code = '0;
    logic            ecall_req = 1'b0;
    logic            irq_ext = 1'b0;
    logic            irq_tmr = 1'b0;
    logic            sret = 1'b0;
    logic            csr_re = 1'b0;
    logic            csr_we = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_illegal;
    logic            rv;
    logic [XLEN-1:0] rpc;
    logic            priv;

    always #10 clk = ~clk;

    trap_seq #(.XLEN(XLEN)) i_trap_seq (
        .clk_i(clk), .rst_ni(rst_n), .cur_pc_i(cur_pc),
        .exc_req_i(exc_req), .exc_code_i(exc_code), .ecall_req_i(ecall_req),
        .irq_ext_i(irq_ext), .irq_tmr_i(irq_tmr), .sret_i(sret),
        .csr_re_i(csr_re), .csr_we_i(csr_we), .csr_addr_i(csr_addr),
        .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .csr_illegal_o(csr_illegal),
        .redirect_valid_o(rv), .redirect_pc_o(rpc), .priv_o(priv)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string req = "R1";

    // reference state
    bit        m_priv = 1, m_sie = 0, m_spie = 0, m_spp = 0, m_rv = 0;
    bit [31:0] m_tvec = 0, m_epc = 0, m_cause = 0, m_scr = 0, m_rpc = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit known_addr(input bit [11:0] a);
        return a == 12'h100 || a == 12'h105 || a == 12'h140 || a == 12'h141 || a == 12'h142;
    endfunction

    function automatic bit [31:0] m_read(input bit [11:0] a);
        case (a)
            12'h100: return (32'(m_sie) << 1) | (32'(m_spie) << 5) | (32'(m_spp) << 8);
            12'h105: return m_tvec;
            12'h140: return m_scr;
            12'h141: return m_epc;
            12'h142: return m_cause;
            default: return 0;
        endcase
    endfunction

    function automatic bit m_illegal();
        return (csr_re || csr_we) && (!m_priv || !known_addr(csr_addr));
    endfunction

    task automatic model_step();
        bit        ill = m_illegal();
        bit        irq = m_sie && (irq_ext || irq_tmr);
        bit [31:0] c;
        m_rv = 0;
        if (exc_req || ecall_req || irq) begin
            if (exc_req)        c = {28'd0, exc_code};
            else if (ecall_req) c = m_priv ? 32'd9 : 32'd8;
            else                c = irq_ext ? 32'h8000_0009 : 32'h8000_0005;
            m_rpc = m_tvec; m_rv = 1;
            m_epc = cur_pc; m_cause = c;
            m_spie = m_sie; m_sie = 0; m_spp = m_priv; m_priv = 1;
        end else if (sret) begin
            m_rpc = m_epc; m_rv = 1;
            m_priv = m_spp; m_sie = m_spie; m_spie = 1; m_spp = 0;
        end else if (csr_we && !ill) begin
            case (csr_addr)
                12'h100: begin m_sie = csr_wdata[1]; m_spie = csr_wdata[5]; m_spp = csr_wdata[8]; end
                12'h105: m_tvec  = {csr_wdata[31:2], 2'b00};
                12'h140: m_scr   = csr_wdata;
                12'h141: m_epc   = csr_wdata;
                12'h142: m_cause = csr_wdata;
                default: ;
            endcase
        end
    endtask

    task automatic tick();
        bit ill;
        #2;
        ill = m_illegal();
        chk(req, "csr_illegal", 32'(csr_illegal), 32'(ill));
        chk(req, "csr_rdata", csr_rdata, (csr_re && !ill) ? m_read(csr_addr) : 32'd0);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(req, "redirect_valid", 32'(rv), 32'(m_rv));
        if (m_rv) chk(req, "redirect_pc", rpc, m_rpc);
        chk(req, "priv", 32'(priv), 32'(m_priv));
    endtask

    task automatic clear_in();
        exc_req = 0; ecall_req = 0; sret = 0; csr_re = 0; csr_we = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin clear_in(); tick(); end
    endtask

    task automatic rd(input bit [11:0] a);
        clear_in(); csr_re = 1; csr_addr = a; tick(); clear_in();
    endtask

    task automatic wr(input bit [11:0] a, input bit [31:0] d);
        clear_in(); csr_we = 1; csr_addr = a; csr_wdata = d; tick(); clear_in();
    endtask

    task automatic rd_all();
        rd(12'h100); rd(12'h105); rd(12'h140); rd(12'h141); rd(12'h142);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        req = "R1"; rd_all(); idle(1);
        // R11: vector alignment and status bit masking
        req = "R11"; wr(12'h105, 32'h0000_1003); rd(12'h105);
        wr(12'h100, 32'hFFFF_FFFF); rd(12'h100); wr(12'h100, 32'h0);
        // R13: scratch storage
        req = "R13"; wr(12'h140, 32'hA5A5_5A5A); rd(12'h140);
        // R2: timer held while enable is clear, then taken once set
        req = "R2"; irq_tmr = 1; idle(4);
        wr(12'h100, 32'h0000_0002);
        req = "R3"; cur_pc = 32'h0000_0400; idle(1); irq_tmr = 0;
        req = "R4"; rd(12'h100);
        req = "R5"; rd(12'h142);
        req = "R3"; rd(12'h141);
        // R8: return in supervisor then to user
        req = "R8"; clear_in(); sret = 1; tick(); rd(12'h100);
        wr(12'h141, 32'h0000_2000); clear_in(); sret = 1; tick(); clear_in();
        // R9: user mode accesses refused
        req = "R9"; rd(12'h105); wr(12'h105, 32'hDEAD_BEEC); wr(12'h140, 32'h1111_1111);
        // R7: user ecall
        req = "R7"; cur_pc = 32'h0000_2000; clear_in(); ecall_req = 1; tick(); clear_in();
        rd(12'h141); req = "R5"; rd(12'h142); req = "R4"; rd(12'h100);
        req = "R9"; rd(12'h105); req = "R13"; rd(12'h140);
        // R5: supervisor ecall
        req = "R5"; cur_pc = 32'h0000_3000; clear_in(); ecall_req = 1; tick(); clear_in(); rd(12'h142);
        // R2: exception taken with enable clear
        req = "R2"; cur_pc = 32'h0000_3004; clear_in(); exc_req = 1; exc_code = 4'd2; tick();
        clear_in(); rd(12'h142);
        // R6: exception beats ecall and interrupt
        req = "R6"; wr(12'h100, 32'h2); irq_ext = 1; irq_tmr = 1;
        cur_pc = 32'h0000_3008; clear_in(); exc_req = 1; ecall_req = 1; exc_code = 4'd2; tick();
        clear_in(); rd(12'h142);
        // R5: external beats timer
        req = "R5"; wr(12'h100, 32'h2); cur_pc = 32'h0000_300C; idle(1);
        irq_ext = 0; irq_tmr = 0; rd(12'h142);
        // R6 / R12: ecall with sret and write in one cycle
        req = "R12"; cur_pc = 32'h0000_4000; clear_in();
        ecall_req = 1; sret = 1; csr_we = 1; csr_addr = 12'h140; csr_wdata = 32'h7777_7777; tick();
        clear_in(); rd(12'h140); rd(12'h141);
        // R12: write dropped on a return
        req = "R12"; clear_in(); sret = 1; csr_we = 1; csr_addr = 12'h105; csr_wdata = 32'h0000_8000; tick();
        clear_in(); rd(12'h105); rd(12'h100);
        // R10: unknown address
        req = "R10"; rd(12'h7C0); wr(12'h144, 32'h5); rd_all();
        // R8: return restores enable from previous-enable
        req = "R8"; wr(12'h100, 32'h0000_0120); wr(12'h141, 32'h0000_5000);
        clear_in(); sret = 1; tick(); clear_in(); rd(12'h100);
        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule